// File: doc/BRIEF.md
# I2C Subaddressed Register Slave

This block is an I2C target that gives a two-wire bus master access to a bank of 256 eight-bit registers. Every access goes through an internal subaddress pointer: the first byte after the device address loads the pointer, and each data byte then moves it one register up. The block runs entirely on a fast system clock. It oversamples SCL and SDA through synchronizers, finds START, repeated START and STOP from edges of the synchronized lines, and pulls SDA low through an output-enable. SDA itself is never driven high.

A write frame is START, the device address with the direction bit clear, the subaddress, any number of data bytes and STOP. The target acknowledges every byte. A read is a combined frame. A write phase sets the subaddress. A repeated START then follows with the direction bit set, and the target returns registers from the pointer onward. The master acknowledges each byte it wants followed by another, and ends with a not-acknowledge. Clock stretching, 10-bit addresses and general call are not supported.

Top module: `i2c_subaddr_slave`

## Requirements
- R1: After reset, SDA is released (`sdaOe` = 0) and every register reads 0x00.
- R2: An address byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. The bytes that follow it are not acknowledged and write nothing until the next START.
- R3: An address byte that matches `DEV_ADDR` is acknowledged by holding SDA low through the 9th clock, whatever the direction bit (bit 0: 0 = write, 1 = read).
- R4: In a write frame, the first byte after the address is acknowledged and loads the pointer. Each later byte is acknowledged and stored in the register the pointer selects.
- R5: The pointer advances by one after each data byte written or read, and wraps from 0xFF to 0x00.
- R6: After an address with the direction bit set, the target shifts out the register at the pointer, MSB first. It changes SDA only while SCL is low.
- R7: A master acknowledge after a read byte makes the target send the next register. A master not-acknowledge releases SDA until the next START or STOP, whatever further clocks arrive.
- R8: After a STOP, SCL pulses without a new START draw no acknowledge and no data from the target.
- R9: The pointer persists across frames, so a read frame without a subaddress write starts at the register after the last one accessed.
- R10: The target changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock level as seen on the pin |
| sdaIn | input | 1 | Bus data level as seen on the pin |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest state to reach from the pins is the one after a master not-acknowledge that is not followed at once by STOP. Here the target must stay silent while the master keeps clocking. The bench ends a read with a not-acknowledge and then sends nine more clocks with SDA released, checking that the line stays high on every one. Pointer wrap is reached by writing three bytes from subaddress 0xFE. Persistence of the pointer is reached by a read frame that carries no subaddress.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } ctrlState_t;

  // Strobes from control to datapath, at most a few set in one cycle
  typedef struct packed {
    logic sampleBit;  // shift SDA into the receive byte, count it
    logic clrCnt;     // zero the bit counter
    logic ackOn;      // pull SDA low for an acknowledge slot
    logic oeOff;      // release SDA
    logic loadPtr;    // pointer takes the received byte
    logic wrReg;      // store received byte at pointer, then step pointer
    logic loadTx;     // fetch register at pointer, present its MSB, step pointer
    logic shiftTx;    // present the next transmit bit
  } strobe_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           strb,
  output logic              evStart,
  output logic              evStop,
  output logic              evRise,
  output logic              evFall,
  output logic              sdaBit,
  output logic [3:0]        bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // Bus conditions: SDA moving while SCL stays high
  assign evStart = sclS & sclD & sdaD & ~sdaS;
  assign evStop  = sclS & sclD & ~sdaD & sdaS;
  assign evRise  = sclS & ~sclD;
  assign evFall  = ~sclS & sclD;
  assign sdaBit  = sdaS;

  logic [BYTE_W-1:0] regBank [DEPTH];
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rdWord;

  assign rdWord = regBank[ptr];

  // Register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regBank[i] <= '0;
    end else if (strb.wrReg) begin
      regBank[ptr] <= rxByte;
    end
  end

  // Receive byte and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else begin
      if (strb.sampleBit) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.clrCnt || strb.loadTx) bitCnt <= '0;
      else if (strb.sampleBit || strb.shiftTx) bitCnt <= bitCnt + 4'd1;
    end
  end

  // Subaddress pointer
  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (strb.loadPtr) ptr <= rxByte[ADDR_W-1:0];
    else if (strb.wrReg || strb.loadTx) ptr <= ptr + 1'b1;
  end

  // Transmit shifter and SDA pull-down enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (strb.loadTx) begin
        txShift <= rdWord;
        sdaOe   <= ~rdWord[BYTE_W-1];
      end else if (strb.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
        sdaOe   <= ~txShift[BYTE_W-2];
      end else if (strb.ackOn) begin
        sdaOe <= 1'b1;
      end else if (strb.oeOff) begin
        sdaOe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evRise,
  input  logic              evFall,
  input  logic              sdaBit,
  input  logic [3:0]        bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  output strobe_t           strb,
  output ctrlState_t        curState
);

  ctrlState_t state, nxt;
  logic rwBit;
  logic mAck;
  logic byteDone;
  logic addrHit;

  assign byteDone = evFall && (bitCnt == 4'd8);
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign curState = state;

  always_comb begin
    strb = '0;
    nxt  = state;
    unique case (state)
      ST_IDLE: ;
      ST_ADDR: begin
        strb.sampleBit = evRise;
        if (byteDone) begin
          if (addrHit) begin
            strb.ackOn = 1'b1;
            nxt        = ST_ADDR_ACK;
          end else begin
            strb.clrCnt = 1'b1;
            nxt         = ST_IGNORE;
          end
        end
      end
      ST_ADDR_ACK: begin
        if (evFall) begin
          if (rwBit) begin
            strb.loadTx = 1'b1;
            nxt         = ST_TX;
          end else begin
            strb.oeOff  = 1'b1;
            strb.clrCnt = 1'b1;
            nxt         = ST_SUB;
          end
        end
      end
      ST_SUB: begin
        strb.sampleBit = evRise;
        if (byteDone) begin
          strb.ackOn   = 1'b1;
          strb.loadPtr = 1'b1;
          nxt          = ST_SUB_ACK;
        end
      end
      ST_SUB_ACK, ST_WDATA_ACK: begin
        if (evFall) begin
          strb.oeOff  = 1'b1;
          strb.clrCnt = 1'b1;
          nxt         = ST_WDATA;
        end
      end
      ST_WDATA: begin
        strb.sampleBit = evRise;
        if (byteDone) begin
          strb.ackOn = 1'b1;
          strb.wrReg = 1'b1;
          nxt        = ST_WDATA_ACK;
        end
      end
      ST_TX: begin
        if (evFall) begin
          if (bitCnt == 4'd7) begin
            strb.oeOff  = 1'b1;
            strb.clrCnt = 1'b1;
            nxt         = ST_RACK;
          end else begin
            strb.shiftTx = 1'b1;
          end
        end
      end
      ST_RACK: begin
        if (evFall) begin
          if (mAck) begin
            strb.loadTx = 1'b1;
            nxt         = ST_TX;
          end else begin
            nxt = ST_IGNORE;
          end
        end
      end
      ST_IGNORE: ;
      default: nxt = ST_IDLE;
    endcase

    // Bus conditions win over any byte-level activity
    if (evStop) begin
      strb       = '0;
      strb.oeOff = 1'b1;
      nxt        = ST_IDLE;
    end else if (evStart) begin
      strb        = '0;
      strb.oeOff  = 1'b1;
      strb.clrCnt = 1'b1;
      nxt         = ST_ADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rwBit <= 1'b0;
      mAck  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && byteDone) rwBit <= rxByte[0];
      if (state == ST_RACK && evRise) mAck <= ~sdaBit;
    end
  end

endmodule

// File: rtl/i2c_subaddr_slave.sv
module i2c_subaddr_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  strobe_t           strb;
  ctrlState_t        curState;
  logic              evStart, evStop, evRise, evFall, sdaBit;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptr;

  i2cs_datapath #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strb   (strb),
    .evStart(evStart),
    .evStop (evStop),
    .evRise (evRise),
    .evFall (evFall),
    .sdaBit (sdaBit),
    .bitCnt (bitCnt),
    .rxByte (rxByte),
    .ptr    (ptr),
    .sdaOe  (sdaOe)
  );

  i2cs_ctrl #(
    .DEV_ADDR(DEV_ADDR)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evStart (evStart),
    .evStop  (evStop),
    .evRise  (evRise),
    .evFall  (evFall),
    .sdaBit  (sdaBit),
    .bitCnt  (bitCnt),
    .rxByte  (rxByte),
    .strb    (strb),
    .curState(curState)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              evStart,
  input logic              evStop,
  input ctrlState_t        state,
  input strobe_t           strb,
  input logic [ADDR_W-1:0] ptr
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R10

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaOe); // R2

  AST_START_REARM: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> (state == ST_ADDR)); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (!sdaOe && state == ST_IDLE)); // R8

  AST_ACK_PULLS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackOn |=> sdaOe); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrReg || strb.loadTx) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R5

endmodule

bind i2c_subaddr_slave i2cs_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .sclIn  (sclIn),
  .sdaOe  (sdaOe),
  .evStart(evStart),
  .evStop (evStop),
  .state  (curState),
  .strb   (strb),
  .ptr    (ptr)
);

// File: tb/i2c_subaddr_slave_tb_top.sv
module i2c_subaddr_slave_tb_top;

  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [7:0] AW  = {DEV, 1'b0};
  localparam logic [7:0] AR  = {DEV, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic mLow = 1'b0;
  logic sdaOe;
  logic sdaBus;

  int nChecks = 0;
  int nFail   = 0;
  int r10Viol = 0;

  always #5 clk = ~clk;

  assign sdaBus = ~(mLow | sdaOe);

  i2c_subaddr_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclLine),
    .sdaIn(sdaBus),
    .sdaOe(sdaOe)
  );

  // Independent observer: target pull-down may only move while SCL is low (R10)
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && sclLine) r10Viol++;
    prevOe <= sdaOe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw;
    repeat (5) @(negedge clk);
  endtask

  task automatic mStart;
    mLow = 1'b0; qw;
    sclLine = 1'b1; qw;
    mLow = 1'b1; qw;
    sclLine = 1'b0; qw;
  endtask

  task automatic mStop;
    mLow = 1'b1; qw;
    sclLine = 1'b1; qw;
    mLow = 1'b0; qw;
  endtask

  task automatic writeBit(input bit b);
    mLow = ~b; qw;
    sclLine = 1'b1; qw; qw;
    sclLine = 1'b0; qw;
  endtask

  task automatic readBit(output bit b);
    mLow = 1'b0; qw;
    sclLine = 1'b1; qw;
    b = sdaBus; qw;
    sclLine = 1'b0; qw;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit giveAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~giveAck);
  endtask

  task automatic writeRegs(input logic [7:0] sub, input logic [7:0] d [4], input int n);
    bit a;
    mStart;
    sendByte(AW, a);
    check(a, "R3 write address ack", a, 1);
    sendByte(sub, a);
    check(a, "R4 subaddress ack", a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a);
      check(a, "R4 data ack", a, 1);
    end
    mStop;
  endtask

  task automatic readRegs(input logic [7:0] sub, input int n, output logic [7:0] q [4]);
    bit a;
    mStart;
    sendByte(AW, a);
    check(a, "R3 address ack before read", a, 1);
    sendByte(sub, a);
    check(a, "R4 subaddress ack before read", a, 1);
    mStart;
    sendByte(AR, a);
    check(a, "R3 read address ack", a, 1);
    for (int i = 0; i < n; i++) recvByte(q[i], (i != n - 1));
    mStop;
  endtask

  // Scenarios
  task automatic tResetState;
    logic [7:0] q [4];
    check(sdaOe == 1'b0, "R1 SDA released after reset", sdaOe, 0);
    readRegs(8'h80, 2, q);
    check(q[0] == 8'h00, "R1 register 0x80 cleared", q[0], 0);
    check(q[1] == 8'h00, "R1 register 0x81 cleared", q[1], 0);
  endtask

  task automatic tWriteRead;
    logic [7:0] d [4];
    logic [7:0] q [4];
    d = '{8'hA5, 8'h3C, 8'hF0, 8'h00};
    writeRegs(8'h10, d, 3);
    readRegs(8'h10, 3, q);
    check(q[0] == 8'hA5, "R6 first read byte", q[0], 8'hA5);
    check(q[1] == 8'h3C, "R7 byte after master ack", q[1], 8'h3C);
    check(q[2] == 8'hF0, "R5 third ascending register", q[2], 8'hF0);
  endtask

  task automatic tWrap;
    logic [7:0] d [4];
    logic [7:0] q [4];
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    writeRegs(8'hFE, d, 3);
    readRegs(8'hFE, 3, q);
    check(q[0] == 8'h11, "R5 register 0xFE", q[0], 8'h11);
    check(q[1] == 8'h22, "R5 register 0xFF", q[1], 8'h22);
    check(q[2] == 8'h33, "R5 read wraps to 0x00", q[2], 8'h33);
    readRegs(8'h00, 1, q);
    check(q[0] == 8'h33, "R5 write wrapped to 0x00", q[0], 8'h33);
  endtask

  task automatic tMismatch;
    bit a;
    logic [7:0] q [4];
    mStart;
    sendByte({7'h2B, 1'b0}, a);
    check(!a, "R2 foreign address not acked", a, 0);
    sendByte(8'h10, a);
    check(!a, "R2 byte after foreign address not acked", a, 0);
    sendByte(8'h99, a);
    check(!a, "R2 data after foreign address not acked", a, 0);
    mStop;
    readRegs(8'h10, 1, q);
    check(q[0] == 8'hA5, "R2 register untouched by foreign frame", q[0], 8'hA5);
  endtask

  task automatic tNackRelease;
    bit a, b;
    int highs;
    logic [7:0] v;
    mStart;
    sendByte(AW, a);
    sendByte(8'h11, a);
    mStart;
    sendByte(AR, a);
    check(a, "R3 read address ack", a, 1);
    recvByte(v, 1'b0);
    check(v == 8'h3C, "R6 single read byte", v, 8'h3C);
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      if (b) highs++;
    end
    check(highs == 9, "R7 SDA released after master NACK", highs, 9);
    mStop;
  endtask

  task automatic tAfterStop;
    bit a;
    bit b;
    int highs;
    sclLine = 1'b0; qw;
    sendByte(AW, a);
    check(!a, "R8 no ack without START", a, 0);
    highs = 0;
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      if (b) highs++;
    end
    check(highs == 9, "R8 no data without START", highs, 9);
    mStop;
  endtask

  task automatic tPointerPersist;
    logic [7:0] d [4];
    logic [7:0] v;
    bit a;
    d = '{8'h88, 8'h00, 8'h00, 8'h00};
    writeRegs(8'h41, d, 1);
    d = '{8'h77, 8'h00, 8'h00, 8'h00};
    writeRegs(8'h40, d, 1);
    mStart;
    sendByte(AR, a);
    check(a, "R9 direct read address ack", a, 1);
    recvByte(v, 1'b0);
    mStop;
    check(v == 8'h88, "R9 read resumes at next register", v, 8'h88);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary;
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tResetState;
    tWriteRead;
    tWrap;
    tMismatch;
    tNackRelease;
    tAfterStop;
    tPointerPersist;
    check(r10Viol == 0, "R10 SDA moved only with SCL low", r10Viol, 0);
    summary;
    $finish;
  end

endmodule